// File: doc/BRIEF.md
# Serial EEPROM Boot Loader

This block is the SPI master that fetches boot code from a single serial EEPROM or flash part and writes it, byte by byte, into on-chip memory. After a start strobe it pulls its one chip-select low, sends the read command, and then feeds zero address bytes to the device. After each zero byte past the first, it checks what comes back. While the device is still taking address bytes, MISO idles high and reads as 0xFF. The first byte that is not 0xFF tells the loader how many address bytes the part uses, and that byte is also the first byte of the boot stream.

The stream is a series of blocks. Each block starts with a 10-byte header that holds a destination address, a byte count and a flag word, and the payload follows it. Payload bytes go out on a simple write port at rising addresses. Loading stops after the block whose flag marks it final. If the device never answers, the loader stops with an error instead. The serial clock is the system clock divided by a fixed parameter.

Top module: `spi_boot_loader`

## Requirements
- R1: Out of reset, and while idle, csN is high, sck is low, and memValid, done and err are low.
- R2: The serial link runs in mode 0. sck idles low, each half-period lasts CLK_DIV clocks, MOSI shifts out MSB first, and MISO is sampled on the rising sck edge. The first byte sent is the read command 0x03.
- R3: csN falls on start and rises exactly once per load, only when the load finishes or fails. sck stays low whenever csN is high.
- R4: After the command, every byte the loader sends is 0x00. Address-width probing works as follows. The reply to the byte that follows the n-th zero address byte (n = 1, 2, 3) is tested. The first reply other than 0xFF sets addrWidth = n, and that reply is taken as header byte 0.
- R5: If the reply after the third address byte is still 0xFF, the loader raises err, releases csN and leaves addrWidth at 0. It makes no memory write, and exactly 5 bytes are clocked in total.
- R6: A header is 10 bytes: destination address (bytes 0-3, little-endian), byte count (bytes 4-7, little-endian), then flag word (bytes 8-9, little-endian).
- R7: Each payload byte produces one memValid pulse. memData carries the byte and memAddr carries the destination plus the byte's offset in the block. The pulses come in stream order.
- R8: A byte count of zero skips the payload, and the next stream byte starts a new header.
- R9: Flag bit 15 marks the final block. Once that block's payload has been written (or at once, if its count is zero), done rises, csN is released, and no further sck pulses occur. The device then sees exactly 8*(1+addrWidth+stream length) rising sck edges.
- R10: Any number of blocks can be loaded in sequence within one chip-select period.
- R11: A start while idle clears done, err and addrWidth before the new load runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle strobe that begins a load when idle |
| miso | input | 1 | Serial data from the device |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the device |
| csN | output | 1 | Active-low chip select |
| memAddr | output | ADDR_W | Write address of the current payload byte |
| memData | output | 8 | Payload byte |
| memValid | output | 1 | One-cycle write strobe |
| done | output | 1 | Load finished after the final block |
| err | output | 1 | No device answered during probing |
| addrWidth | output | PW | Detected number of address bytes (1 to MAX_ADDR_BYTES) |

## Verification
The hardest paths to reach are the deep end of the probe: a device that needs all three address bytes, and a device that never answers. From the ports, both depend entirely on how long MISO stays high. The bench device model therefore takes the address width as a setting, with zero meaning an absent part, and replies 0xFF for exactly that many address bytes. Every width is then run against directed and random block streams, including zero-count blocks and a final block with no payload.

// File: rtl/spi_boot_pkg.sv
package spi_boot_pkg;

  localparam logic [7:0] READ_CMD   = 8'h03;
  localparam logic [7:0] IDLE_REPLY = 8'hFF;
  localparam int         HDR_BYTES  = 10;

  // strobes from control to datapath
  typedef struct packed {
    logic kick;      // start one byte exchange
    logic sendCmd;   // byte to send is the read command, else 0x00
    logic shiftHdr;  // push received byte into header register
    logic loadBlk;   // load address/count counters from header
    logic wrMem;     // write received byte to memory port
    logic csOn;      // assert chip select
    logic csOff;     // release chip select
  } ctlStrb_t;

  // status from datapath to control
  typedef struct packed {
    logic       byteDone;
    logic [7:0] rxByte;
    logic       cntZero;
    logic       lastFinal;
    logic       lastByte;
  } dpStat_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_PROBE, ST_HDR, ST_EVAL, ST_PAY
  } ldState_t;

endpackage

// File: rtl/spi_boot_dp.sv
module spi_boot_dp
  import spi_boot_pkg::*;
#(
  parameter int CLK_DIV = 2,
  parameter int ADDR_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrb_t          ctl,
  input  logic              miso,
  output dpStat_t           stat,
  output logic              sck,
  output logic              mosi,
  output logic              csN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData,
  output logic              memValid
);

  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int HDR_W = 8 * HDR_BYTES;

  logic [DIV_W-1:0]  divCnt;
  logic [2:0]        bitCnt;
  logic [7:0]        txSh;
  logic [7:0]        rxSh;
  logic              busy;
  logic              sckR;
  logic              doneP;
  logic              csR;
  logic [HDR_W-1:0]  hdrSh;
  logic [ADDR_W-1:0] addrCnt;
  logic [31:0]       remCnt;
  logic              halfEnd;

  assign halfEnd = (divCnt == DIV_W'(CLK_DIV - 1));

  // byte engine: mode 0, MSB first
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      sckR   <= 1'b0;
      doneP  <= 1'b0;
      divCnt <= '0;
      bitCnt <= '0;
      txSh   <= '0;
      rxSh   <= '0;
    end else begin
      doneP <= 1'b0;
      if (ctl.kick) begin
        busy   <= 1'b1;
        txSh   <= ctl.sendCmd ? READ_CMD : 8'h00;
        bitCnt <= '0;
        divCnt <= '0;
        sckR   <= 1'b0;
      end else if (busy) begin
        if (halfEnd) begin
          divCnt <= '0;
          if (!sckR) begin
            sckR <= 1'b1;
            rxSh <= {rxSh[6:0], miso};
          end else begin
            sckR <= 1'b0;
            if (bitCnt == 3'd7) begin
              busy  <= 1'b0;
              doneP <= 1'b1;
            end else begin
              bitCnt <= bitCnt + 3'd1;
              txSh   <= {txSh[6:0], 1'b0};
            end
          end
        end else begin
          divCnt <= divCnt + DIV_W'(1);
        end
      end
    end
  end

  // chip select, header capture, block counters, write port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      csR      <= 1'b1;
      hdrSh    <= '0;
      addrCnt  <= '0;
      remCnt   <= '0;
      memAddr  <= '0;
      memData  <= '0;
      memValid <= 1'b0;
    end else begin
      memValid <= 1'b0;
      if (ctl.csOn)  csR <= 1'b0;
      if (ctl.csOff) csR <= 1'b1;
      if (ctl.shiftHdr) hdrSh <= {rxSh, hdrSh[HDR_W-1:8]};
      if (ctl.loadBlk) begin
        addrCnt <= ADDR_W'(hdrSh[31:0]);
        remCnt  <= hdrSh[63:32];
      end else if (ctl.wrMem) begin
        memAddr  <= addrCnt;
        memData  <= rxSh;
        memValid <= 1'b1;
        addrCnt  <= addrCnt + ADDR_W'(1);
        remCnt   <= remCnt - 32'd1;
      end
    end
  end

  assign sck  = sckR;
  assign csN  = csR;
  assign mosi = busy ? txSh[7] : 1'b0;

  assign stat.byteDone  = doneP;
  assign stat.rxByte    = rxSh;
  assign stat.cntZero   = (hdrSh[63:32] == 32'd0);
  assign stat.lastFinal = hdrSh[HDR_W-1];
  assign stat.lastByte  = (remCnt == 32'd1);

  AST_CS_HIGH_SCK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sck);                                      // R3
  AST_KICK_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.kick |-> !busy);                                // R2
  AST_IDLE_SCK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sck);                                    // R2
  AST_WRITE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrMem |-> doneP);                               // R7

endmodule

// File: rtl/spi_boot_ctrl.sv
module spi_boot_ctrl
  import spi_boot_pkg::*;
#(
  parameter int MAX_ADDR_BYTES = 3,
  parameter int PW             = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  dpStat_t       stat,
  output ctlStrb_t      ctl,
  output logic          done,
  output logic          err,
  output logic [PW-1:0] addrWidth
);

  ldState_t      st;
  logic [PW-1:0] probeCnt;
  logic [3:0]    hdrIdx;
  logic          gotReply;
  logic          probeLimit;
  logic          hdrLast;

  assign gotReply   = (stat.rxByte != IDLE_REPLY);
  assign probeLimit = (probeCnt == PW'(MAX_ADDR_BYTES));
  assign hdrLast    = (hdrIdx == 4'(HDR_BYTES - 1));

  always_comb begin
    ctl = '0;
    case (st)
      ST_IDLE: if (start) begin
        ctl.csOn    = 1'b1;
        ctl.kick    = 1'b1;
        ctl.sendCmd = 1'b1;
      end
      ST_CMD, ST_ADDR: if (stat.byteDone) ctl.kick = 1'b1;
      ST_PROBE: if (stat.byteDone) begin
        if (gotReply) begin
          ctl.shiftHdr = 1'b1;
          ctl.kick     = 1'b1;
        end else if (probeLimit) begin
          ctl.csOff = 1'b1;
        end else begin
          ctl.kick = 1'b1;
        end
      end
      ST_HDR: if (stat.byteDone) begin
        ctl.shiftHdr = 1'b1;
        if (!hdrLast) ctl.kick = 1'b1;
      end
      ST_EVAL: begin
        ctl.loadBlk = 1'b1;
        if (stat.cntZero && stat.lastFinal) ctl.csOff = 1'b1;
        else                                ctl.kick  = 1'b1;
      end
      ST_PAY: if (stat.byteDone) begin
        ctl.wrMem = 1'b1;
        if (stat.lastByte && stat.lastFinal) ctl.csOff = 1'b1;
        else                                 ctl.kick  = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st        <= ST_IDLE;
      probeCnt  <= '0;
      hdrIdx    <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
      addrWidth <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          done      <= 1'b0;
          err       <= 1'b0;
          addrWidth <= '0;
          st        <= ST_CMD;
        end
        ST_CMD: if (stat.byteDone) st <= ST_ADDR;
        ST_ADDR: if (stat.byteDone) begin
          probeCnt <= PW'(1);
          st       <= ST_PROBE;
        end
        ST_PROBE: if (stat.byteDone) begin
          if (gotReply) begin
            addrWidth <= probeCnt;
            hdrIdx    <= 4'd1;
            st        <= ST_HDR;
          end else if (probeLimit) begin
            err <= 1'b1;
            st  <= ST_IDLE;
          end else begin
            probeCnt <= probeCnt + PW'(1);
          end
        end
        ST_HDR: if (stat.byteDone) begin
          if (hdrLast) st <= ST_EVAL;
          else         hdrIdx <= hdrIdx + 4'd1;
        end
        ST_EVAL: begin
          if (stat.cntZero && stat.lastFinal) begin
            done <= 1'b1;
            st   <= ST_IDLE;
          end else if (stat.cntZero) begin
            hdrIdx <= '0;
            st     <= ST_HDR;
          end else begin
            st <= ST_PAY;
          end
        end
        ST_PAY: if (stat.byteDone && stat.lastByte) begin
          if (stat.lastFinal) begin
            done <= 1'b1;
            st   <= ST_IDLE;
          end else begin
            hdrIdx <= '0;
            st     <= ST_HDR;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(done && err));                                    // R9
  AST_ERR_NO_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(err) |-> (addrWidth == '0));                  // R5
  AST_DONE_RELEASES_CS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(ctl.csOff));                  // R9
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_IDLE && start) |=> (!done && !err));      // R11

endmodule

// File: rtl/spi_boot_loader.sv
module spi_boot_loader
  import spi_boot_pkg::*;
#(
  parameter int CLK_DIV        = 2,
  parameter int ADDR_W         = 32,
  parameter int MAX_ADDR_BYTES = 3,
  parameter int PW             = $clog2(MAX_ADDR_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              csN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData,
  output logic              memValid,
  output logic              done,
  output logic              err,
  output logic [PW-1:0]     addrWidth
);

  ctlStrb_t ctl;
  dpStat_t  stat;

  spi_boot_ctrl #(
    .MAX_ADDR_BYTES(MAX_ADDR_BYTES),
    .PW            (PW)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .stat     (stat),
    .ctl      (ctl),
    .done     (done),
    .err      (err),
    .addrWidth(addrWidth)
  );

  spi_boot_dp #(
    .CLK_DIV(CLK_DIV),
    .ADDR_W (ADDR_W)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .miso    (miso),
    .stat    (stat),
    .sck     (sck),
    .mosi    (mosi),
    .csN     (csN),
    .memAddr (memAddr),
    .memData (memData),
    .memValid(memValid)
  );

endmodule

// File: tb/tb_spi_boot_loader.sv
module tb_spi_boot_loader;

  localparam int ADDR_W = 32;
  localparam int PW     = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic miso = 1'b1;
  logic sck, mosi, csN, memValid, done, err;
  logic [ADDR_W-1:0] memAddr;
  logic [7:0] memData;
  logic [PW-1:0] addrWidth;

  always #5 clk = ~clk;

  spi_boot_loader #(.CLK_DIV(2), .ADDR_W(ADDR_W), .MAX_ADDR_BYTES(3)) dut (
    .clk(clk), .rstN(rstN), .start(start), .miso(miso), .sck(sck),
    .mosi(mosi), .csN(csN), .memAddr(memAddr), .memData(memData),
    .memValid(memValid), .done(done), .err(err), .addrWidth(addrWidth)
  );

  int nChecks = 0;
  int nErr = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // device model and stream image
  int devAw = 1;             // 0 = no device answering
  logic [7:0] img [256];
  int imgLen = 0;
  logic [31:0] expA [256];
  logic [7:0]  expD [256];
  int expN = 0;
  int riseCnt = 0;
  logic [7:0] cmdCap = 8'h00;
  logic mosiOr = 1'b0;
  int csRise = 0;
  int wrCnt = 0;
  int wrBad = 0;

  function automatic logic devBit(int n);
    int b;
    b = n / 8;
    if (devAw == 0 || b <= devAw) return 1'b1;
    if (b - devAw - 1 >= imgLen) return 1'b1;
    return img[b - devAw - 1][7 - (n % 8)];
  endfunction

  always @(negedge csN) begin
    riseCnt = 0;
    cmdCap  = 8'h00;
    mosiOr  = 1'b0;
    miso    = devBit(0);
  end

  always @(posedge csN) csRise++;

  always @(posedge sck) begin
    if (!csN) begin
      if (riseCnt < 8) cmdCap = {cmdCap[6:0], mosi};
      else mosiOr = mosiOr | mosi;
      riseCnt++;
    end
  end

  always @(negedge sck) if (!csN) miso = devBit(riseCnt);

  // write port monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (memValid) begin
      if (wrCnt >= expN || memAddr != expA[wrCnt] || memData != expD[wrCnt]) begin
        wrBad++;
        if (wrCnt < expN)
          $display("FAIL R7 write %0d: actual %0h:%0h expected %0h:%0h",
                   wrCnt, memAddr, memData, expA[wrCnt], expD[wrCnt]);
        else
          $display("FAIL R7 extra write %0d: actual %0h expected none", wrCnt, memAddr);
      end
      wrCnt++;
    end
  end

  task automatic clearImg();
    imgLen = 0;
    expN = 0;
  endtask

  task automatic pushByte(input logic [7:0] b);
    img[imgLen] = b;
    imgLen++;
  endtask

  // R6: header is dest(4 LE), count(4 LE), flags(2 LE); R8 count 0 has no payload
  task automatic addBlock(input logic [31:0] dest, input int cnt, input logic [15:0] flg);
    for (int i = 0; i < 4; i++) pushByte(dest[8*i +: 8]);
    for (int i = 0; i < 4; i++) pushByte(8'(cnt >> (8*i)));
    pushByte(flg[7:0]);
    pushByte(flg[15:8]);
    for (int i = 0; i < cnt; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      pushByte(d);
      expA[expN] = dest + 32'(i);
      expD[expN] = d;
      expN++;
    end
  endtask

  task automatic runLoad(input int aw, input string tag);
    int t;
    devAw = aw;
    wrCnt = 0;
    wrBad = 0;
    csRise = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    // R11: flags cleared after start
    check(!done && !err && addrWidth == 0, "R11", {tag, " clear on start"},
          {done, err}, 0);
    check(!csN, "R3", {tag, " cs low during load"}, csN, 0);
    t = 0;
    while (!done && !err && t < 20000) begin
      @(negedge clk);
      t++;
    end
    check(t < 20000, "R9", {tag, " load finished"}, t, 20000);
    repeat (20) @(negedge clk);
    check(cmdCap == 8'h03, "R2", {tag, " command byte"}, cmdCap, 8'h03);
    check(mosiOr == 1'b0, "R4", {tag, " zero bytes after command"}, mosiOr, 0);
    check(csN && csRise == 1, "R3", {tag, " single cs release"}, csRise, 1);
    check(!sck, "R1", {tag, " sck idle low"}, sck, 0);
    if (aw == 0) begin
      check(err && !done, "R5", {tag, " error raised"}, {done, err}, 2'b01);
      check(addrWidth == 0, "R5", {tag, " no width"}, addrWidth, 0);
      check(riseCnt == 40, "R5", {tag, " probe bytes"}, riseCnt, 40);
      check(wrCnt == 0, "R5", {tag, " no writes"}, wrCnt, 0);
    end else begin
      check(done && !err, "R9", {tag, " done raised"}, {done, err}, 2'b10);
      check(addrWidth == PW'(aw), "R4", {tag, " width detect"}, addrWidth, aw);
      check(riseCnt == 8 * (1 + aw + imgLen), "R9", {tag, " no extra clocks"},
            riseCnt, 8 * (1 + aw + imgLen));
      check(wrCnt == expN && wrBad == 0, "R7", {tag, " write stream"}, wrCnt, expN);
    end
  endtask

  initial begin
    #1_500_000;
    nErr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'hB0075EED));
    repeat (4) @(negedge clk);
    // R1 reset state
    check(csN && !sck && !memValid && !done && !err, "R1", "reset outputs",
          {csN, sck, memValid, done, err}, 5'b10000);
    @(negedge clk) rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(csN && !sck && !memValid, "R1", "idle outputs", {csN, sck, memValid}, 3'b100);

    // R10 R8: several blocks, zero count in the middle, 1-byte address
    clearImg();
    addBlock(32'hFFA0_0000, 3, 16'h0000);
    addBlock(32'h0000_0020, 0, 16'h0001);
    addBlock(32'h1000_0040, 2, 16'h8000);
    runLoad(1, "dir-w1");

    // R9: final block with zero count, 2-byte address
    clearImg();
    addBlock(32'h2000_0010, 4, 16'h0000);
    addBlock(32'h0000_0000, 0, 16'h8000);
    runLoad(2, "dir-w2-final0");

    // R5: no device
    clearImg();
    addBlock(32'h0000_0001, 1, 16'h8000);
    runLoad(0, "absent");

    // R4: 3-byte address, single one-byte block
    clearImg();
    addBlock(32'hFFA0_0005, 1, 16'h8000);
    runLoad(3, "dir-w3");

    // random streams
    for (int r = 0; r < 6; r++) begin
      int nb, aw;
      nb = 1 + int'($urandom % 4);
      aw = 1 + int'($urandom % 3);
      clearImg();
      for (int b = 0; b < nb; b++) begin
        logic [31:0] dst;
        logic [15:0] flg;
        dst = {24'($urandom), 8'($urandom % 255)};  // low byte never 0xFF
        flg = (b == nb - 1) ? 16'h8000 : (16'($urandom) & 16'h7FFF);
        addBlock(dst, int'($urandom % 6), flg);
      end
      runLoad(aw, $sformatf("rnd%0d", r));
    end

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule